// File: doc/BRIEF.md
# Byte-Serial Peripheral Port with Status Flags

This block is a byte-wide SPI port that runs either as the clock-driving master or as a slave clocked from outside. Firmware uses a small register bus with three addresses: a control register, a status/control register and a data register. The control register picks the role, the clock polarity, the clock phase and one of four master bit rates. The status register reports transfer completion, overrun, mode fault and transmit-buffer-empty conditions. It also holds the bit-order select and two interrupt enables. One interrupt line combines the flags.

A write to the data register fills a one-byte transmit buffer. In master mode the byte moves into the shifter as soon as the port is idle and enabled. In slave mode it moves when the external select goes low. The received byte is held in a receive register. The completion flag is acknowledged by a status read followed by a data-register access. A byte that arrives while the flag is still pending is dropped and raises overrun. A select conflict in master mode turns the port off. In slave mode it only abandons the byte in flight.

Top module: `spi_port`

## Requirements
- R1: After reset the control register (address 0) reads 0x14, the status register (address 1) reads 0x08, the data register (address 2) reads 0x00, and the interrupt output is low.
- R2: The control register layout is bit 6 enable, bit 4 master, bit 3 clock polarity, bit 2 clock phase, and bits 1:0 rate. In master mode SCK idles at the polarity level and each half period lasts 2·2^rate system clocks, so SCK runs at the system clock divided by 4, 8, 16 or 32.
- R3: With clock phase 0, data is sampled on the edge where SCK leaves idle. With phase 1, data is sampled on the edge where SCK returns to idle. A master transfer sends the buffer byte on MOSI and captures the MISO byte correctly in all four polarity/phase combinations.
- R4: Status bit 2 set sends and receives the least significant bit first. Clear, the most significant bit goes first.
- R5: Status bit 7 (complete) sets when the eighth bit has been shifted, and the received byte reads at address 2. The flag clears only after a status read that sees it set is followed by a read or write of address 2. A data access with no prior status read leaves it set.
- R6: If a byte completes while status bit 7 is still set, status bit 5 (overrun) sets and the receive register keeps the earlier byte. A status read clears bit 5.
- R7: Status bit 3 (transmit empty) clears when address 2 is written and sets again when the buffered byte moves into the shifter.
- R8: In enabled master mode, SS driven low sets status bit 4 (mode fault), clears control bit 6 and releases the SCK and MOSI drivers. A status read clears bit 4.
- R9: In slave mode, with SS low, the port receives a byte on MOSI and sends the buffered byte on MISO, using externally driven SCK, in all four polarity/phase combinations.
- R10: In slave mode, SS going high after at least one SCK edge of a byte sets status bit 4, discards the partial byte without setting bit 7, and a later byte under SS low completes normally.
- R11: In slave mode, the MISO output enable is low while SS is high and high while SS is low.
- R12: The interrupt output is high when status bit 7 is set, when bit 3 and bit 1 are both set, or when bit 4 and bit 0 are both set, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (status and data reads have side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| irq_o | output | 1 | Combined interrupt request |
| sck_i | input | 1 | Serial clock input in slave mode |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | SCK driver enable |
| mosi_i | input | 1 | Serial data input in slave mode |
| mosi_o | output | 1 | Serial data output in master mode |
| mosi_oe | output | 1 | MOSI driver enable |
| miso_i | input | 1 | Serial data input in master mode |
| miso_o | output | 1 | Serial data output in slave mode |
| miso_oe | output | 1 | MISO driver enable |
| ss_i | input | 1 | Select input, active low |

## Verification
The assertions assume that SCK, MOSI and SS change no faster than the two-stage input synchronizers can follow. They also assume that MISO is stable at the master's sample edges, and that firmware does not change the control register while a byte is in flight. The stimulus keeps slave-side SCK half periods at eight system clocks. It moves MISO only right after the master's shift edges. Every configuration write happens while the port is idle, so each checked property sees only orderly traffic.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ADR_CTRL = 2'd0,
        ADR_STAT = 2'd1,
        ADR_DATA = 2'd2,
        ADR_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic       rsv7;
        logic       en;
        logic       rsv5;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = ctrl_t'(8'h14);

    typedef struct packed {
        logic lsb_first;
        logic txe_ie;
        logic modf_ie;
    } stat_cfg_t;

    // system clocks per SCK half period
    function automatic int unsigned half_period(input logic [1:0] rate);
        return 32'd2 << rate;
    endfunction

    // shift a received bit into the capture register
    function automatic logic [BYTE_W-1:0] push_bit(input logic [BYTE_W-1:0] sh,
                                                   input logic b, input logic lsb);
        return lsb ? {b, sh[BYTE_W-1:1]} : {sh[BYTE_W-2:0], b};
    endfunction

    // advance the transmit register by one bit
    function automatic logic [BYTE_W-1:0] drop_bit(input logic [BYTE_W-1:0] sh,
                                                   input logic lsb);
        return lsb ? {1'b0, sh[BYTE_W-1:1]} : {sh[BYTE_W-2:0], 1'b0};
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int             W       = 3,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/spi_sckgen.sv
module spi_sckgen
    import spi_port_pkg::*;
#(
    parameter int DIV_W = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [1:0] rate,
    input  logic       cpol,
    output logic       sck,
    output logic       tick,
    output logic       lead
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;
    logic             lvl;

    assign lim  = DIV_W'(half_period(rate) - 1);
    assign tick = run && (cnt == lim);
    assign lead = ~lvl;
    assign sck  = cpol ^ lvl;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            lvl <= 1'b0;
        end else if (cnt == lim) begin
            cnt <= '0;
            lvl <= ~lvl;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              load,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              tick,
    input  logic              lead,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              sdi,
    output logic              sdo,
    output logic              active,
    output logic              mid,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int EDGES = 2 * BYTE_W;
    localparam int CNT_W = $clog2(EDGES);

    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] rx_sh;
    logic              sample_edge;

    assign sample_edge = lead ^ cpha;
    assign sdo     = lsb_first ? tx_sh[0] : tx_sh[BYTE_W-1];
    assign mid     = active && (cnt != '0);
    assign rx_byte = rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                active <= 1'b0;
                cnt    <= '0;
            end else if (load) begin
                active <= 1'b1;
                cnt    <= '0;
                tx_sh  <= tx_byte;
            end else if (active && tick) begin
                if (sample_edge)
                    rx_sh <= push_bit(rx_sh, sdi, lsb_first);
                else if (!(cpha && cnt == '0))
                    tx_sh <= drop_bit(tx_sh, lsb_first);
                if (cnt == CNT_W'(EDGES - 1)) begin
                    active <= 1'b0;
                    cnt    <= '0;
                    done   <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R3
    load_start_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !abort) |=> active);
endmodule

// File: rtl/spi_regs.sv
module spi_regs
    import spi_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output ctrl_t             ctrl,
    output stat_cfg_t         scfg,
    output logic [BYTE_W-1:0] tx_buf,
    output logic              txe,
    output logic              irq,
    input  logic              done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              tx_take,
    input  logic              modf_evt,
    input  logic              mfault
);
    ctrl_t             ctrl_q;
    stat_cfg_t         scfg_q;
    logic              spif_q, ovr_q, modf_q, armed_q, txe_q;
    logic [BYTE_W-1:0] rx_q, txb_q;
    logic              stat_rd, data_acc, clr;

    assign stat_rd  = rd_en && (reg_addr_e'(addr) == ADR_STAT);
    assign data_acc = (rd_en || wr_en) && (reg_addr_e'(addr) == ADR_DATA);
    assign clr      = armed_q && data_acc;

    assign ctrl   = ctrl_q;
    assign scfg   = scfg_q;
    assign tx_buf = txb_q;
    assign txe    = txe_q;
    assign irq    = spif_q || (txe_q && scfg_q.txe_ie) || (modf_q && scfg_q.modf_ie);

    always_comb begin
        case (reg_addr_e'(addr))
            ADR_CTRL: rdata = ctrl_q;
            ADR_STAT: rdata = {spif_q, 1'b0, ovr_q, modf_q, txe_q, scfg_q};
            ADR_DATA: rdata = rx_q;
            default:  rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= CTRL_RST;
            scfg_q  <= '0;
            spif_q  <= 1'b0;
            ovr_q   <= 1'b0;
            modf_q  <= 1'b0;
            armed_q <= 1'b0;
            txe_q   <= 1'b1;
            rx_q    <= '0;
            txb_q   <= '0;
        end else begin
            if (wr_en && reg_addr_e'(addr) == ADR_CTRL)
                ctrl_q <= ctrl_t'(wdata);
            if (mfault)
                ctrl_q.en <= 1'b0;
            if (wr_en && reg_addr_e'(addr) == ADR_STAT)
                scfg_q <= stat_cfg_t'(wdata[2:0]);

            if (tx_take)
                txe_q <= 1'b1;
            if (wr_en && reg_addr_e'(addr) == ADR_DATA) begin
                txb_q <= wdata;
                txe_q <= 1'b0;
            end

            if (done) begin
                if (spif_q && !clr) begin
                    ovr_q <= 1'b1;
                end else begin
                    rx_q   <= rx_byte;
                    spif_q <= 1'b1;
                end
            end else if (clr) begin
                spif_q <= 1'b0;
            end

            if (clr)
                armed_q <= 1'b0;
            else if (stat_rd && spif_q)
                armed_q <= 1'b1;

            if (stat_rd)
                ovr_q <= 1'b0;
            if (done && spif_q && !clr)
                ovr_q <= 1'b1;

            if (stat_rd)
                modf_q <= 1'b0;
            if (modf_evt)
                modf_q <= 1'b1;
        end
    end

    // R6
    ovr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (spif_q && !clr) |=> $stable(rx_q));
    // R5
    spif_clr_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(spif_q) |-> $past(armed_q && data_acc));
    // R8
    mfault_en_chk: assert property (@(posedge clk) disable iff (rst)
        mfault |=> !ctrl_q.en);
    // R7
    txe_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_addr_e'(addr) == ADR_DATA) |=> !txe_q);
endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DIV_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              irq_o,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              ss_i
);
    ctrl_t             ctrl;
    stat_cfg_t         scfg;
    logic [BYTE_W-1:0] tx_buf, rx_byte;
    logic              txe;
    logic              ss_s, sck_s, mosi_s, sck_q, ss_q;
    logic              m_sel, s_sel;
    logic              m_tick, m_lead, m_sck;
    logic              eng_tick, eng_lead, eng_sdi, eng_sdo;
    logic              eng_active, eng_mid, eng_done;
    logic              m_fault, s_fault, m_start, s_start, load, abort;

    spi_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ss_i, sck_i, mosi_i}),
        .q   ({ss_s, sck_s, mosi_s})
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            ss_q  <= 1'b1;
        end else begin
            sck_q <= sck_s;
            ss_q  <= ss_s;
        end
    end

    assign m_sel   = ctrl.en && ctrl.master;
    assign s_sel   = ctrl.en && !ctrl.master;
    assign m_fault = m_sel && !ss_s;
    assign s_fault = s_sel && ss_s && eng_mid;
    assign m_start = m_sel && ss_s && !eng_active && !txe;
    assign s_start = s_sel && !ss_s && (ss_q || eng_done);
    assign load    = m_start || s_start;
    assign abort   = !ctrl.en || m_fault || (s_sel && ss_s);

    assign eng_tick = ctrl.master ? m_tick : (s_sel && !ss_s && (sck_s != sck_q));
    assign eng_lead = ctrl.master ? m_lead : (sck_s != ctrl.cpol);
    assign eng_sdi  = ctrl.master ? miso_i : mosi_s;

    spi_sckgen #(.DIV_W(DIV_W)) u_sckgen (
        .clk  (clk),
        .rst  (rst),
        .run  (eng_active && ctrl.master),
        .rate (ctrl.rate),
        .cpol (ctrl.cpol),
        .sck  (m_sck),
        .tick (m_tick),
        .lead (m_lead)
    );

    spi_shift_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .abort     (abort),
        .load      (load),
        .tx_byte   (tx_buf),
        .tick      (eng_tick),
        .lead      (eng_lead),
        .cpha      (ctrl.cpha),
        .lsb_first (scfg.lsb_first),
        .sdi       (eng_sdi),
        .sdo       (eng_sdo),
        .active    (eng_active),
        .mid       (eng_mid),
        .done      (eng_done),
        .rx_byte   (rx_byte)
    );

    spi_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .wr_en    (bus_wr),
        .rd_en    (bus_rd),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .ctrl     (ctrl),
        .scfg     (scfg),
        .tx_buf   (tx_buf),
        .txe      (txe),
        .irq      (irq_o),
        .done     (eng_done),
        .rx_byte  (rx_byte),
        .tx_take  (load),
        .modf_evt (m_fault || s_fault),
        .mfault   (m_fault)
    );

    assign sck_o   = m_sck;
    assign sck_oe  = m_sel;
    assign mosi_o  = eng_sdo;
    assign mosi_oe = m_sel;
    assign miso_o  = eng_sdo;
    assign miso_oe = s_sel && !ss_s;

    // R8
    mfault_release_chk: assert property (@(posedge clk) disable iff (rst)
        m_fault |=> !sck_oe && !mosi_oe);
    // R10
    sfault_nodone_chk: assert property (@(posedge clk) disable iff (rst)
        s_fault |=> !eng_done && !eng_active);
endmodule

// File: tb/test_spi_port.sv
`timescale 1ns/1ps
module test_spi_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = 2'd3;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_o, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
    logic       sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_i = 1'b1;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    spi_port i_spi_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_i(ss_i)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'd3;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 2'd3;
    endtask

    function automatic logic pick(input logic [7:0] v, input int i, input logic lsb);
        return lsb ? v[i] : v[7-i];
    endfunction

    task automatic wait_irq();
        for (int w = 0; w < 3000 && !irq_o; w++) @(negedge clk);
    endtask

    // master transfer with the bench acting as the slave
    task automatic m_xfer(input logic [1:0] rate, input logic cpol, input logic cpha,
                          input logic lsb, input logic [7:0] tx, input logic [7:0] sv);
        logic [7:0] got, s, d;
        time t0, t15;
        int idx, si;
        got = 8'h00; idx = 0; si = 0; t0 = 0; t15 = 0;
        reg_wr(2'd1, {5'b0, lsb, 2'b00});
        reg_wr(2'd0, 8'h50 | (8'(cpol) << 3) | (8'(cpha) << 2) | 8'(rate));
        miso_i = pick(sv, 0, lsb);
        fork
            reg_wr(2'd2, tx);
            begin
                for (int k = 0; k < 16; k++) begin
                    @(sck_o);
                    if (k == 0) t0 = $time;
                    if (k == 15) t15 = $time;
                    if (((k % 2) == 0) ^ cpha) begin
                        if (lsb) got[si] = mosi_o; else got[7-si] = mosi_o;
                        si++;
                    end else if (!(cpha && k == 0)) begin
                        idx++;
                        #1 if (idx < 8) miso_i = pick(sv, idx, lsb);
                    end
                end
            end
        join
        wait_irq();
        reg_rd(2'd1, s);
        chk("R5 complete flag", s[7], 1);
        reg_rd(2'd2, d);
        chk(lsb ? "R3/R4 rx lsb-first" : "R3 rx msb-first", d, sv);
        chk(lsb ? "R3/R4 tx lsb-first" : "R3 tx msb-first", got, tx);
        chk("R2 half period", int'((t15 - t0) / 15), 20 * (2 << rate));
        chk("R2 idle level", sck_o, cpol);
        reg_rd(2'd1, s);
        chk("R5 cleared by sequence", s[7], 0);
    endtask

    // slave transfer with the bench acting as the master
    task automatic s_xfer(input logic cpol, input logic cpha, input logic lsb,
                          input logic [7:0] mb, input logic [7:0] sb);
        logic [7:0] got, s, d;
        int idx, si;
        got = 8'h00; idx = 0; si = 0;
        reg_wr(2'd1, {5'b0, lsb, 2'b00});
        reg_wr(2'd0, 8'h40 | (8'(cpol) << 3) | (8'(cpha) << 2));
        @(negedge clk); sck_i = cpol; ss_i = 1'b1;
        repeat (4) @(negedge clk);
        reg_wr(2'd2, sb);
        mosi_i = pick(mb, 0, lsb);
        ss_i = 1'b0;
        repeat (8) @(negedge clk);
        chk("R11 miso driven under select", miso_oe, 1);
        for (int k = 0; k < 16; k++) begin
            if (((k % 2) == 0) ^ cpha) begin
                if (lsb) got[si] = miso_o; else got[7-si] = miso_o;
                si++;
            end
            sck_i = ~sck_i;
            if (!(((k % 2) == 0) ^ cpha) && !(cpha && k == 0)) begin
                idx++;
                if (idx < 8) mosi_i = pick(mb, idx, lsb);
            end
            repeat (8) @(negedge clk);
        end
        ss_i = 1'b1;
        repeat (6) @(negedge clk);
        chk("R11 miso released", miso_oe, 0);
        wait_irq();
        reg_rd(2'd1, s);
        chk("R9 slave complete", s[7], 1);
        reg_rd(2'd2, d);
        chk("R9 slave rx", d, mb);
        chk("R9 slave tx", got, sb);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] s, d;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", irq_o, 0);
        chk("R1 sck_oe", sck_oe, 0);
        reg_rd(2'd0, d); chk("R1 control", d, 8'h14);
        reg_rd(2'd1, s); chk("R1 status", s, 8'h08);
        reg_rd(2'd2, d); chk("R1 data", d, 8'h00);

        // master sweep: rates x modes x order
        n = 0;
        for (int r = 0; r < 4; r++)
            for (int m = 0; m < 4; m++)
                for (int o = 0; o < 2; o++) begin
                    m_xfer(2'(r), m[1], m[0], o[0], 8'(n * 29 + 3), 8'(n * 53 + 150));
                    n++;
                end

        // R5 data access alone leaves the flag
        reg_wr(2'd1, 8'h00);
        reg_wr(2'd0, 8'h50);
        miso_i = 1'b1;
        reg_wr(2'd2, 8'h3C);
        wait_irq();
        reg_rd(2'd2, d); chk("R5 data", d, 8'hFF);
        reg_rd(2'd1, s); chk("R5 flag kept without status read", s[7], 1);
        reg_rd(2'd2, d);
        reg_rd(2'd1, s); chk("R5 flag cleared after sequence", s[7], 0);

        // R6 overrun keeps earlier byte
        reg_wr(2'd2, 8'h11);
        wait_irq();
        repeat (4) @(negedge clk);
        miso_i = 1'b0;
        reg_wr(2'd2, 8'h22);
        repeat (200) @(negedge clk);
        reg_rd(2'd1, s); chk("R6 overrun and complete", s & 8'hA0, 8'hA0);
        reg_rd(2'd2, d); chk("R6 earlier byte kept", d, 8'hFF);
        reg_rd(2'd1, s); chk("R6 overrun cleared", s & 8'hA0, 8'h00);

        // R7 transmit empty
        reg_wr(2'd0, 8'h10);
        reg_wr(2'd2, 8'h5A);
        reg_rd(2'd1, s); chk("R7 empty cleared on write", s[3], 0);
        // R12 no interrupt while nothing pending
        chk("R12 irq low", irq_o, 0);
        reg_wr(2'd0, 8'h50);
        repeat (3) @(negedge clk);
        reg_rd(2'd1, s); chk("R7 empty after move", s[3], 1);
        wait_irq();
        reg_rd(2'd1, s);
        reg_rd(2'd2, d);
        chk("R12 irq after clear", irq_o, 0);
        reg_wr(2'd1, 8'h02);
        @(negedge clk);
        chk("R12 irq from empty enable", irq_o, 1);
        reg_wr(2'd1, 8'h00);
        @(negedge clk);
        chk("R12 irq off with enable low", irq_o, 0);

        // R8 master mode fault
        reg_wr(2'd1, 8'h01);
        ss_i = 1'b0;
        repeat (6) @(negedge clk);
        chk("R12 irq from fault", irq_o, 1);
        chk("R8 sck released", sck_oe, 0);
        chk("R8 mosi released", mosi_oe, 0);
        reg_rd(2'd0, d); chk("R8 enable cleared", d, 8'h10);
        ss_i = 1'b1;
        repeat (4) @(negedge clk);
        reg_rd(2'd1, s); chk("R8 fault flag", s[4], 1);
        reg_rd(2'd1, s); chk("R8 fault cleared by read", s[4], 0);
        reg_wr(2'd1, 8'h00);

        // slave sweep
        n = 0;
        for (int m = 0; m < 4; m++)
            for (int o = 0; o < 2; o++) begin
                s_xfer(m[1], m[0], o[0], 8'(n * 71 + 9), 8'(n * 37 + 200));
                n++;
            end

        // R10 slave fault mid-byte
        reg_wr(2'd0, 8'h40);
        @(negedge clk); sck_i = 1'b0;
        reg_wr(2'd2, 8'h77);
        ss_i = 1'b0;
        repeat (8) @(negedge clk);
        chk("R11 slave drives under select", miso_oe, 1);
        for (int k = 0; k < 5; k++) begin
            sck_i = ~sck_i;
            repeat (8) @(negedge clk);
        end
        ss_i = 1'b1;
        repeat (8) @(negedge clk);
        sck_i = 1'b0;
        repeat (8) @(negedge clk);
        reg_rd(2'd1, s);
        chk("R10 fault flag", s[4], 1);
        chk("R10 no completion", s[7], 0);
        reg_rd(2'd1, s); chk("R10 fault cleared", s[4], 0);
        s_xfer(1'b0, 1'b0, 1'b0, 8'hC3, 8'h5E);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule